// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs one processor access at a time on an external parallel bus. An internal requester presents a space code, a direction, an address, write data and a per-access software wait-state count. The block then drives active-low space selects and strobes, a read/write line and the address and write data. It stretches the access by the programmed number of wait cycles, and it can stretch it further from an external READY input. When the access ends, it returns a one-clock done pulse together with the captured read data.

A microstate-complete output marks the software wait cycles. If that output is wired back to READY, it adds exactly one external wait cycle. An external master can take the bus through a HOLD/HOLDA handshake. The grant is given only between accesses. While the grant is held, every bus output is released and internal requests are refused through a busy indication. A global output-off input withdraws all output enables. The pads themselves lie outside the block, so releasing an output is expressed as a low enable signal.

Top module: `ebus_ctrl`

## Requirements
- R1: After reset and between accesses, ds_n_o, ps_n_o, is_n_o, mstrb_n_o, iostrb_n_o, rw_o and msc_n_o are high, and holda_o, done_o and busy_o are low.
- R2: A request is accepted on a clock edge where busy_o is low and req_i is high. The access then occupies the following cycles. In each of them exactly one select is low: ds_n_o for space_i=0 (data), ps_n_o for space_i=1 (program), is_n_o for space_i=2 or 3 (I/O). The latched address is on bus_addr_o throughout.
- R3: mstrb_n_o is low in every access cycle of a data or program access. iostrb_n_o is low in every access cycle of an I/O access. Both are high otherwise.
- R4: rw_o is low and data_oe_o is high only during the cycles of a write access, with the latched write data on bus_wdata_o.
- R5: An access with software wait count N (ws_i, 0 to 7) lasts N+1 cycles when READY does not extend it. done_o is high for exactly one cycle, the cycle after the last access cycle. For a read, rdata_o then holds the bus_rdata_i value sampled in the last access cycle.
- R6: With N of 2 or more, ready_i is sampled at the end of the last software wait cycle. Each low sample adds one more cycle, in which ready_i is sampled again, until a high sample ends the access.
- R7: With N of 0 or 1, ready_i has no effect and the access lasts N+1 cycles.
- R8: msc_n_o is low exactly in the software wait cycles (access cycles 2 to N+1) and high in the first access cycle and in any READY-extension cycle. With msc_n_o fed to ready_i, an access with N of 2 or more lasts N+2 cycles.
- R9: hold_i raised during an access does not shorten it. holda_o rises two cycles after the last access cycle and stays low in every access cycle. While holda_o is high, bus_oe_o is low. holda_o falls one cycle after hold_i is removed.
- R10: busy_o is high during an access, whenever hold_i is high while idle, and while holda_o is high. A request presented while busy_o is high starts no access.
- R11: With off_ni low, bus_oe_o, data_oe_o and aux_oe_o are low whatever the hold state. Access sequencing and done_o are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| off_ni | input | 1 | Global output-off, active low |
| req_i | input | 1 | Internal access request |
| space_i | input | 2 | 0 data, 1 program, 2 or 3 I/O |
| wr_i | input | 1 | 1 write, 0 read |
| addr_i | input | AW | Access address |
| wdata_i | input | DW | Write data |
| ws_i | input | WSW | Software wait-state count |
| busy_o | output | 1 | Request cannot be accepted |
| done_o | output | 1 | One-cycle access-complete pulse |
| rdata_o | output | DW | Captured read data |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | DW | Bus write data |
| bus_rdata_i | input | DW | Bus read data |
| ds_n_o | output | 1 | Data space select, active low |
| ps_n_o | output | 1 | Program space select, active low |
| is_n_o | output | 1 | I/O space select, active low |
| mstrb_n_o | output | 1 | Memory strobe, active low |
| iostrb_n_o | output | 1 | I/O strobe, active low |
| rw_o | output | 1 | High read, low write |
| ready_i | input | 1 | External ready |
| msc_n_o | output | 1 | Microstate complete, active low |
| hold_i | input | 1 | External bus request |
| holda_o | output | 1 | Bus granted |
| bus_oe_o | output | 1 | Enable for address, selects, strobes, rw |
| data_oe_o | output | 1 | Enable for write data |
| aux_oe_o | output | 1 | Enable for holda_o and msc_n_o |

## Verification
The bench builds the block with its defaults: 16-bit address and data and a 3-bit wait-state count. The 3-bit count makes the whole range of 0 to 7 software wait cycles reachable. That range includes both sides of the two-cycle READY threshold and the longest programmable access. Directed accesses cover every space code, including the spare I/O code, both directions, READY held low for several cycles, READY ignored below the threshold, and microstate-complete looped back. A hold is raised in the middle of an access, and the off input is driven low during an access.

// File: rtl/ebus_pkg.sv
package ebus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_SWAIT = 3'd2,
    ST_XWAIT = 3'd3,
    ST_HOLD  = 3'd4
  } ebus_st_e;

  localparam logic [1:0] SP_DATA = 2'd0;
  localparam logic [1:0] SP_PROG = 2'd1;
endpackage

// File: rtl/ebus_wait_ctr.sv
module ebus_wait_ctr #(
  parameter int WSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [WSW-1:0] ws_i,
  input  logic           step_i,
  output logic           zero_o,
  output logic           last_o,
  output logic           rdy_en_o
);
  logic [WSW-1:0] ws_q, cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ws_q  <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      ws_q  <= ws_i;
      cnt_q <= ws_i;
    end else if (step_i) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o   = (ws_q == '0);
  assign last_o   = (cnt_q == WSW'(1));
  assign rdy_en_o = (ws_q >= WSW'(2));

  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> (cnt_q != '0));
endmodule

// File: rtl/ebus_pin_ctl.sv
module ebus_pin_ctl (
  input  logic       active_i,
  input  logic [1:0] sp_i,
  input  logic       wr_i,
  input  logic       hold_gnt_i,
  input  logic       off_ni,
  output logic       ds_n_o,
  output logic       ps_n_o,
  output logic       is_n_o,
  output logic       mstrb_n_o,
  output logic       iostrb_n_o,
  output logic       rw_o,
  output logic       bus_oe_o,
  output logic       data_oe_o,
  output logic       aux_oe_o
);
  import ebus_pkg::*;
  logic io_sp;

  assign io_sp      = sp_i[1];
  assign ds_n_o     = !(active_i && sp_i == SP_DATA);
  assign ps_n_o     = !(active_i && sp_i == SP_PROG);
  assign is_n_o     = !(active_i && io_sp);
  assign mstrb_n_o  = !(active_i && !io_sp);
  assign iostrb_n_o = !(active_i && io_sp);
  assign rw_o       = !(active_i && wr_i);
  assign bus_oe_o   = off_ni && !hold_gnt_i;
  assign data_oe_o  = bus_oe_o && active_i && wr_i;
  assign aux_oe_o   = off_ni;
endmodule

// File: rtl/ebus_ctrl.sv
module ebus_ctrl #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int WSW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           off_ni,
  input  logic           req_i,
  input  logic [1:0]     space_i,
  input  logic           wr_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [WSW-1:0] ws_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [DW-1:0]  rdata_o,
  output logic [AW-1:0]  bus_addr_o,
  output logic [DW-1:0]  bus_wdata_o,
  input  logic [DW-1:0]  bus_rdata_i,
  output logic           ds_n_o,
  output logic           ps_n_o,
  output logic           is_n_o,
  output logic           mstrb_n_o,
  output logic           iostrb_n_o,
  output logic           rw_o,
  input  logic           ready_i,
  output logic           msc_n_o,
  input  logic           hold_i,
  output logic           holda_o,
  output logic           bus_oe_o,
  output logic           data_oe_o,
  output logic           aux_oe_o
);
  import ebus_pkg::*;

  ebus_st_e      state_q, state_d;
  logic [1:0]    sp_q;
  logic          wr_q, done_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          accept, complete, active;
  logic          ws_zero, ws_last, rdy_en, step;

  assign accept = (state_q == ST_IDLE) && !hold_i && req_i;
  assign active = (state_q == ST_LEAD) || (state_q == ST_SWAIT) || (state_q == ST_XWAIT);
  assign step   = (state_q == ST_SWAIT) && !ws_last;

  always_comb begin
    state_d  = state_q;
    complete = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (hold_i) state_d = ST_HOLD;
                else if (req_i) state_d = ST_LEAD;
      ST_LEAD:  if (ws_zero) begin
                  complete = 1'b1;
                  state_d  = ST_IDLE;
                end else state_d = ST_SWAIT;
      ST_SWAIT: if (ws_last) begin
                  if (rdy_en && !ready_i) state_d = ST_XWAIT;
                  else begin
                    complete = 1'b1;
                    state_d  = ST_IDLE;
                  end
                end
      ST_XWAIT: if (ready_i) begin
                  complete = 1'b1;
                  state_d  = ST_IDLE;
                end
      ST_HOLD:  if (!hold_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sp_q    <= '0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= complete;
      if (accept) begin
        sp_q    <= space_i;
        wr_q    <= wr_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (complete && !wr_q) rdata_q <= bus_rdata_i;
    end
  end

  ebus_wait_ctr #(.WSW(WSW)) u_wait (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .ws_i     (ws_i),
    .step_i   (step),
    .zero_o   (ws_zero),
    .last_o   (ws_last),
    .rdy_en_o (rdy_en)
  );

  ebus_pin_ctl u_pins (
    .active_i   (active),
    .sp_i       (sp_q),
    .wr_i       (wr_q),
    .hold_gnt_i (holda_o),
    .off_ni     (off_ni),
    .ds_n_o     (ds_n_o),
    .ps_n_o     (ps_n_o),
    .is_n_o     (is_n_o),
    .mstrb_n_o  (mstrb_n_o),
    .iostrb_n_o (iostrb_n_o),
    .rw_o       (rw_o),
    .bus_oe_o   (bus_oe_o),
    .data_oe_o  (data_oe_o),
    .aux_oe_o   (aux_oe_o)
  );

  assign busy_o      = (state_q != ST_IDLE) || hold_i;
  assign done_o      = done_q;
  assign rdata_o     = rdata_q;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign msc_n_o     = (state_q != ST_SWAIT);
  assign holda_o     = (state_q == ST_HOLD);

  assert_one_sel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ds_n_o, ps_n_o, is_n_o}) >= 2);
  assert_strobe_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mstrb_n_o && !iostrb_n_o));
  assert_rw_in_access_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rw_o |-> !(ds_n_o && ps_n_o && is_n_o));
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_xwait_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XWAIT) |-> rdy_en);
  assert_msc_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ds_n_o && ps_n_o && is_n_o) |-> msc_n_o);
  assert_grant_between_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(holda_o) |-> $past(state_q == ST_IDLE));
  assert_hold_release_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holda_o |-> !bus_oe_o);
  assert_busy_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    holda_o |-> busy_o);
  assert_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !off_ni |-> (!aux_oe_o && !data_oe_o));
endmodule

// File: tb/ebus_ctrl_tb.sv
module ebus_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        off_ni = 1'b1;
  logic        req_i = 1'b0;
  logic [1:0]  space_i = '0;
  logic        wr_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [2:0]  ws_i = '0;
  logic [15:0] bus_rdata_i = '0;
  logic        hold_i = 1'b0;
  logic        ready_r = 1'b1;
  logic        loop_mode = 1'b0;
  logic        ready_i;
  logic        busy_o, done_o, ds_n_o, ps_n_o, is_n_o, mstrb_n_o, iostrb_n_o, rw_o;
  logic        msc_n_o, holda_o, bus_oe_o, data_oe_o, aux_oe_o;
  logic [15:0] rdata_o, bus_addr_o, bus_wdata_o;
  int checks = 0;
  int fails = 0;
  int seq = 0;

  always #4 clk_i = ~clk_i;
  assign ready_i = loop_mode ? msc_n_o : ready_r;

  ebus_ctrl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .off_ni(off_ni), .req_i(req_i),
    .space_i(space_i), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .ws_i(ws_i), .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i),
    .ds_n_o(ds_n_o), .ps_n_o(ps_n_o), .is_n_o(is_n_o), .mstrb_n_o(mstrb_n_o),
    .iostrb_n_o(iostrb_n_o), .rw_o(rw_o), .ready_i(ready_i), .msc_n_o(msc_n_o),
    .hold_i(hold_i), .holda_o(holda_o), .bus_oe_o(bus_oe_o),
    .data_oe_o(data_oe_o), .aux_oe_o(aux_oe_o)
  );

  task automatic chk(input logic ok, input string tg, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tg, what, act, exp);
    end
  endtask

  function automatic logic bus_idle();
    return ds_n_o && ps_n_o && is_n_o;
  endfunction

  task automatic t_reset();
    logic [9:0] got;
    got = {ds_n_o, ps_n_o, is_n_o, mstrb_n_o, iostrb_n_o, rw_o, msc_n_o,
           holda_o, done_o, busy_o};
    chk(got == 10'b1111111000, "R1", "idle pins after reset", got, 10'b1111111000);
  endtask

  task automatic t_access(input logic [1:0] sp, input logic wr, input int ws,
                          input int k, input logic lp, input string tg);
    int c, bad_pin, bad_msc, exp_len;
    logic [15:0] a, d, rd;
    logic [4:0] exp_pins, got_pins;
    seq++;
    a  = 16'hA000 ^ 16'(seq * 291);
    d  = 16'h5A00 + 16'(seq);
    rd = 16'hC300 ^ 16'(seq * 77);
    exp_len = 1 + ws + ((ws >= 2) ? (lp ? 1 : k) : 0);
    exp_pins = {sp != 2'd0, sp != 2'd1, !sp[1], sp[1], !sp[1]};
    bad_pin = 0;
    bad_msc = 0;
    @(negedge clk_i);
    loop_mode = lp;
    ready_r = (k == 0);
    bus_rdata_i = rd;
    req_i = 1'b1; space_i = sp; wr_i = wr; addr_i = a; wdata_i = d; ws_i = 3'(ws);
    @(negedge clk_i);
    req_i = 1'b0;
    c = 1;
    while (!bus_idle() && c < 40) begin
      got_pins = {ds_n_o, ps_n_o, is_n_o, mstrb_n_o, iostrb_n_o};
      if (got_pins != exp_pins || rw_o != !wr || bus_addr_o != a || !busy_o ||
          (wr && (bus_wdata_o != d || data_oe_o != off_ni)) || (!wr && data_oe_o))
        bad_pin++;
      if (msc_n_o != !(c >= 2 && c <= 1 + ws)) bad_msc++;
      if (k > 0 && c == 1 + ws + k) ready_r = 1'b1;
      @(negedge clk_i);
      c++;
    end
    chk(bad_pin == 0, "R2", "select/strobe/rw/addr cycles wrong", bad_pin, 0);
    chk(bad_msc == 0, "R8", "msc_n_o cycles wrong", bad_msc, 0);
    chk(c - 1 == exp_len, tg, "access length", c - 1, exp_len);
    chk(done_o == 1'b1, "R5", "done after last cycle", done_o, 1);
    if (!wr) chk(rdata_o == rd, "R5", "read data", rdata_o, rd);
    ready_r = 1'b1;
    loop_mode = 1'b0;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R5", "done one cycle", done_o, 0);
  endtask

  task automatic t_hold();
    int c, bad;
    @(negedge clk_i);
    ready_r = 1'b1;
    req_i = 1'b1; space_i = 2'd0; wr_i = 1'b0; ws_i = 3'd3; addr_i = 16'h0042;
    @(negedge clk_i);
    req_i = 1'b0;
    c = 1;
    bad = 0;
    while (!bus_idle() && c < 40) begin
      if (c == 2) hold_i = 1'b1;
      if (holda_o) bad++;
      @(negedge clk_i);
      c++;
    end
    chk(c - 1 == 4, "R9", "access length under hold", c - 1, 4);
    chk(bad == 0, "R9", "holda in access", bad, 0);
    chk(holda_o == 1'b0 && busy_o == 1'b1, "R10", "idle with hold pending",
        {holda_o, busy_o}, 2'b01);
    @(negedge clk_i);
    chk(holda_o == 1'b1 && bus_oe_o == 1'b0, "R9", "grant and release",
        {holda_o, bus_oe_o}, 2'b10);
    req_i = 1'b1;
    bad = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      if (!bus_idle() || done_o || !busy_o) bad++;
    end
    req_i = 1'b0;
    chk(bad == 0, "R10", "request during hold started access", bad, 0);
    hold_i = 1'b0;
    @(negedge clk_i);
    chk(holda_o == 1'b0 && bus_oe_o == 1'b1, "R9", "hold drop",
        {holda_o, bus_oe_o}, 2'b01);
    chk(bus_idle() && !done_o, "R10", "no late access after hold", done_o, 0);
  endtask

  task automatic t_off();
    @(negedge clk_i);
    off_ni = 1'b0;
    #1;
    chk({bus_oe_o, data_oe_o, aux_oe_o} == 3'b000, "R11", "off enables",
        {bus_oe_o, data_oe_o, aux_oe_o}, 0);
    t_access(2'd0, 1'b1, 2, 0, 1'b0, "R11");
    off_ni = 1'b1;
    #1;
    chk(bus_oe_o && aux_oe_o, "R11", "enables restored", {bus_oe_o, aux_oe_o}, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    checks++;
    $display("FAIL watchdog: run hung actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_access(2'd0, 1'b0, 0, 0, 1'b0, "R5");
    t_access(2'd1, 1'b1, 1, 0, 1'b0, "R5");
    t_access(2'd2, 1'b0, 2, 0, 1'b0, "R6");
    t_access(2'd3, 1'b1, 4, 0, 1'b0, "R3");
    t_access(2'd0, 1'b1, 3, 2, 1'b0, "R6");
    t_access(2'd1, 1'b0, 7, 1, 1'b0, "R6");
    t_access(2'd2, 1'b0, 2, 4, 1'b0, "R6");
    t_access(2'd0, 1'b0, 1, 3, 1'b0, "R7");
    t_access(2'd1, 1'b1, 0, 3, 1'b0, "R7");
    t_access(2'd0, 1'b0, 2, 0, 1'b1, "R8");
    t_access(2'd2, 1'b1, 5, 0, 1'b1, "R8");
    t_access(2'd1, 1'b0, 1, 0, 1'b1, "R8");
    t_access(2'd1, 1'b0, 7, 0, 1'b0, "R4");
    t_hold();
    t_access(2'd2, 1'b1, 0, 0, 1'b0, "R9");
    t_off();
    @(negedge clk_i);
    t_reset();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule